// File: doc/BRIEF.md
# IPv4 Prefix Classifier with Reloadable Table

The block keeps a table of sixteen IPv4 prefixes. Each prefix is a base address plus a count of leading bits that must agree. Every clock cycle it can take one 32-bit address and report the index of the table entry whose prefix contains that address. All entries are compared in parallel, so a new address can be presented on every cycle and each result appears one register stage later.

The table is replaced through a narrow byte port while a load strobe is held high. A load carries sixteen five-byte records in entry order. Each record holds four address bytes, most significant first, then a length byte. The incoming records build a shadow table. The running classifier keeps using the previous table until the strobe drops after a complete load. From the first cycle with the strobe low, the new table is in use. A load that stops early is discarded.

Top module: `ipv4_range_classifier`

## Requirements
- R1: While reset is asserted, res_vld_o, res_hit_o and res_idx_o are 0. After reset and before the first complete load, every valid query reports res_hit_o=0.
- R2: A load is an ordered byte stream with ld_active_i high. Byte k goes to entry k/5. Positions 0 to 3 of a record are the base address, most significant byte first. Position 4 is the length.
- R3: A length N gives a mask with the top N address bits set. N=0 matches every address, and any N above 32 acts as 32.
- R4: An address matches an entry when its top N bits equal those of the entry's base. The query is sampled at a rising edge, and after that same edge the outputs show res_vld_o=1, res_hit_o=1 and res_idx_o equal to the entry index.
- R5: Queries on consecutive cycles each get their own result on consecutive cycles, with no stall.
- R6: A valid query that matches no entry gives res_vld_o=1, res_hit_o=0 and res_idx_o=0.
- R7: res_vld_o is qry_vld_i registered. When qry_vld_i is 0, the next outputs are res_vld_o=0, res_hit_o=0 and res_idx_o=0.
- R8: After a complete load, a query sampled at the first edge with ld_active_i low already uses the new table. The active table does not change while ld_active_i is high.
- R9: If ld_active_i falls after fewer than 80 bytes, the load is discarded and the previous table stays active.
- R10: Bytes beyond the 80th in one load window are ignored.
- R11: Each load window restarts at entry 0 and fully replaces the previous table.
- R12: Base address bits below the prefix length have no effect on matching.
- R13: When several entries match, the lowest index is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| arst_n_i | input | 1 | Asynchronous reset, active low |
| qry_addr_i | input | 32 | Address to classify |
| qry_vld_i | input | 1 | Query present this cycle |
| ld_byte_i | input | 8 | Table load byte |
| ld_active_i | input | 1 | Load window strobe |
| res_idx_o | output | 4 | Index of matching entry, 0 on miss |
| res_vld_o | output | 1 | Result corresponds to a query |
| res_hit_o | output | 1 | Some entry matched |

## Verification
The byte counter and the shadow table are not visible at the ports. An error in either shows up only after the next load, when the lookups that follow report a wrong index. The load cases are therefore each followed at once by lookups that expose a misplaced byte, a wrong mask or a lost commit. The result register differs from the comparator in the very next cycle, so back-to-back query vectors catch it one cycle after the faulty query.

// File: rtl/ipcls_pkg.sv
package ipcls_pkg;
  localparam int ADDR_W = 32;
  localparam int ABYTES = ADDR_W / 8;
  localparam int REC_BYTES = ABYTES + 1;

  // Length byte -> mask with the top N bits set, N clamped to ADDR_W.
  function automatic logic [ADDR_W-1:0] prefix_mask(input logic [7:0] len);
    logic [ADDR_W-1:0] m;
    int n;
    n = (int'(len) > ADDR_W) ? ADDR_W : int'(len);
    for (int j = 0; j < ADDR_W; j++) m[j] = (j >= ADDR_W - n);
    return m;
  endfunction
endpackage

// File: rtl/ipcls_loader.sv
module ipcls_loader
  import ipcls_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic                         clk_i,
  input  logic                         arst_n_i,
  input  logic                         ld_active_i,
  input  logic [7:0]                   ld_byte_i,
  output logic [N_ENT-1:0][ADDR_W-1:0] view_base_o,
  output logic [N_ENT-1:0][ADDR_W-1:0] view_mask_o,
  output logic                         view_ok_o
);
  localparam int IW = $clog2(N_ENT);
  localparam int PW = $clog2(REC_BYTES);

  logic [IW:0]   ent_q;
  logic [PW-1:0] pos_q;
  logic          ld_prev_q;
  logic          act_ok_q;
  logic [N_ENT-1:0][ADDR_W-1:0] shd_base_q, shd_mask_q, act_base_q, act_mask_q;

  // named events
  logic full_w, fall_w, commit_w, abort_w;
  assign full_w   = (ent_q == (IW+1)'(N_ENT));
  assign fall_w   = ld_prev_q & ~ld_active_i;
  assign commit_w = fall_w & full_w;
  assign abort_w  = fall_w & ~full_w;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      ent_q      <= '0;
      pos_q      <= '0;
      ld_prev_q  <= 1'b0;
      shd_base_q <= '0;
      shd_mask_q <= '0;
    end else begin
      ld_prev_q <= ld_active_i;
      if (!ld_active_i) begin
        ent_q <= '0;
        pos_q <= '0;
      end else if (!full_w) begin
        if (int'(pos_q) == REC_BYTES - 1) begin
          shd_mask_q[ent_q[IW-1:0]] <= prefix_mask(ld_byte_i);
          pos_q <= '0;
          ent_q <= ent_q + 1'b1;
        end else begin
          shd_base_q[ent_q[IW-1:0]][(ABYTES - 1 - int'(pos_q)) * 8 +: 8] <= ld_byte_i;
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      act_base_q <= '0;
      act_mask_q <= '0;
      act_ok_q   <= 1'b0;
    end else if (commit_w) begin
      act_base_q <= shd_base_q;
      act_mask_q <= shd_mask_q;
      act_ok_q   <= 1'b1;
    end
  end

  // The table just finished is visible in the very cycle it commits.
  assign view_base_o = commit_w ? shd_base_q : act_base_q;
  assign view_mask_o = commit_w ? shd_mask_q : act_mask_q;
  assign view_ok_o   = act_ok_q | commit_w;

  AST_ENT_BOUND: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    ent_q <= (IW+1)'(N_ENT)); // R10
  AST_ACT_FROZEN_IN_LOAD: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    ld_active_i |=> ($stable(act_base_q) && $stable(act_mask_q))); // R8
  AST_ABORT_KEEPS: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    abort_w |=> ($stable(act_base_q) && $stable(act_mask_q) && $stable(act_ok_q))); // R9
  AST_TABLE_STICKY: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    act_ok_q |=> act_ok_q); // R11
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    !ld_active_i |=> (ent_q == '0 && pos_q == '0)); // R11
endmodule

// File: rtl/ipcls_match.sv
module ipcls_match
  import ipcls_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IW = $clog2(N_ENT)
) (
  input  logic                         clk_i,
  input  logic                         arst_n_i,
  input  logic [ADDR_W-1:0]            qry_addr_i,
  input  logic                         qry_vld_i,
  input  logic [N_ENT-1:0][ADDR_W-1:0] tbl_base_i,
  input  logic [N_ENT-1:0][ADDR_W-1:0] tbl_mask_i,
  input  logic                         tbl_ok_i,
  output logic [IW-1:0]                res_idx_o,
  output logic                         res_vld_o,
  output logic                         res_hit_o
);
  logic [N_ENT-1:0] hit_vec_w;
  logic             any_hit_w;
  logic [IW-1:0]    enc_idx_w;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit_vec_w[i] = tbl_ok_i & ~|((qry_addr_i ^ tbl_base_i[i]) & tbl_mask_i[i]);
  end

  assign any_hit_w = |hit_vec_w;

  always_comb begin
    enc_idx_w = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (hit_vec_w[i]) enc_idx_w = IW'(i);
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      res_vld_o <= 1'b0;
      res_hit_o <= 1'b0;
      res_idx_o <= '0;
    end else begin
      res_vld_o <= qry_vld_i;
      res_hit_o <= qry_vld_i & any_hit_w;
      res_idx_o <= (qry_vld_i & any_hit_w) ? enc_idx_w : '0;
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    qry_vld_i |=> res_vld_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    !qry_vld_i |=> (!res_vld_o && !res_hit_o && res_idx_o == '0)); // R7
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    !res_hit_o |-> res_idx_o == '0); // R6
  AST_EMPTY_MISS: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    !tbl_ok_i |=> !res_hit_o); // R1
  AST_MATCH_REPORTED: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    (qry_vld_i && any_hit_w) |=> res_hit_o); // R4
endmodule

// File: rtl/ipv4_range_classifier.sv
module ipv4_range_classifier
  import ipcls_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IW = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              arst_n_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  input  logic              qry_vld_i,
  input  logic [7:0]        ld_byte_i,
  input  logic              ld_active_i,
  output logic [IW-1:0]     res_idx_o,
  output logic              res_vld_o,
  output logic              res_hit_o
);
  logic [N_ENT-1:0][ADDR_W-1:0] tbl_base_w, tbl_mask_w;
  logic                         tbl_ok_w;

  ipcls_loader #(.N_ENT(N_ENT)) u_loader (
    .clk_i       (clk_i),
    .arst_n_i    (arst_n_i),
    .ld_active_i (ld_active_i),
    .ld_byte_i   (ld_byte_i),
    .view_base_o (tbl_base_w),
    .view_mask_o (tbl_mask_w),
    .view_ok_o   (tbl_ok_w)
  );

  ipcls_match #(.N_ENT(N_ENT)) u_match (
    .clk_i      (clk_i),
    .arst_n_i   (arst_n_i),
    .qry_addr_i (qry_addr_i),
    .qry_vld_i  (qry_vld_i),
    .tbl_base_i (tbl_base_w),
    .tbl_mask_i (tbl_mask_w),
    .tbl_ok_i   (tbl_ok_w),
    .res_idx_o  (res_idx_o),
    .res_vld_o  (res_vld_o),
    .res_hit_o  (res_hit_o)
  );

  AST_NO_HIT_WHILE_LOADING: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    (ld_active_i && !qry_vld_i) |=> !res_vld_o); // R7
endmodule

// File: tb/ipv4_range_classifier_tb_top.sv
module ipv4_range_classifier_tb_top;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic [31:0] qry_addr = '0;
  logic        qry_vld = 1'b0;
  logic [7:0]  ld_byte = '0;
  logic        ld_active = 1'b0;
  logic [3:0]  res_idx;
  logic        res_vld, res_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ipv4_range_classifier dut_i (
    .clk_i(clk), .arst_n_i(arst_n), .qry_addr_i(qry_addr), .qry_vld_i(qry_vld),
    .ld_byte_i(ld_byte), .ld_active_i(ld_active),
    .res_idx_o(res_idx), .res_vld_o(res_vld), .res_hit_o(res_hit));

  logic [31:0] t_base [16];
  logic [7:0]  t_len  [16];

  // {vld, addr, hit, idx}
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 8'd10,  8'd3,   8'd200, 8'd1,   1'b1, 4'd3},
    {1'b1, 8'd10,  8'd1,   8'd0,   8'd0,   1'b1, 4'd1},
    {1'b1, 8'd10,  8'd7,   8'd255, 8'd255, 1'b1, 4'd7},
    {1'b1, 8'd10,  8'd8,   8'd0,   8'd1,   1'b0, 4'd0},
    {1'b1, 8'd192, 8'd168, 8'd5,   8'd9,   1'b1, 4'd13},
    {1'b0, 8'd10,  8'd3,   8'd0,   8'd0,   1'b0, 4'd0},
    {1'b1, 8'd192, 8'd168, 8'd6,   8'd0,   1'b0, 4'd0},
    {1'b1, 8'd8,   8'd8,   8'd8,   8'd8,   1'b1, 4'd14},
    {1'b1, 8'd8,   8'd8,   8'd8,   8'd9,   1'b0, 4'd0},
    {1'b1, 8'd100, 8'd127, 8'd255, 8'd255, 1'b1, 4'd15},
    {1'b1, 8'd100, 8'd128, 8'd0,   8'd0,   1'b0, 4'd0},
    {1'b1, 8'd100, 8'd64,  8'd0,   8'd0,   1'b1, 4'd15},
    {1'b1, 8'd10,  8'd0,   8'd0,   8'd0,   1'b1, 4'd0}
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {vld,hit,idx} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_table_a();
    for (int i = 0; i < 8; i++) begin t_base[i] = {8'd10, 8'(i), 16'd0}; t_len[i] = 8'd16; end
    t_base[1] = {8'd10, 8'd1, 8'd55, 8'd66};
    for (int i = 8; i < 14; i++) begin t_base[i] = {8'd192, 8'd168, 8'(i - 8), 8'd0}; t_len[i] = 8'd24; end
    t_base[14] = {8'd8, 8'd8, 8'd8, 8'd8};   t_len[14] = 8'd32;
    t_base[15] = {8'd100, 8'd64, 8'd0, 8'd0}; t_len[15] = 8'd10;
  endtask

  task automatic set_table_b();
    t_base[0] = {8'd1, 8'd2, 8'd3, 8'd4}; t_len[0] = 8'd40;
    for (int i = 1; i < 15; i++) begin t_base[i] = {8'd2, 8'd0, 8'd0, 8'(i)}; t_len[i] = 8'd32; end
    t_base[15] = '0; t_len[15] = 8'd0;
  endtask

  function automatic logic [7:0] byte_at(input int k);
    int e, p;
    if (k >= 80) return 8'hFF;
    e = k / 5; p = k % 5;
    if (p < 4) return t_base[e][31 - 8 * p -: 8];
    return t_len[e];
  endfunction

  // Entered and left at a falling edge; leaves the strobe low.
  task automatic do_load(input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      ld_active = 1'b1;
      ld_byte = byte_at(k);
      @(negedge clk);
    end
    ld_active = 1'b0;
    ld_byte = '0;
  endtask

  task automatic q1(input logic [31:0] a, input logic h, input logic [3:0] i, input string req);
    qry_addr = a; qry_vld = 1'b1;
    @(negedge clk);
    chk(req, {res_vld, res_hit, res_idx}, {1'b1, h, i});
    qry_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {res_vld, res_hit, res_idx}, 6'd0);
    arst_n = 1'b1;
    @(negedge clk);
    q1({8'd10, 8'd3, 8'd0, 8'd1}, 1'b0, 4'd0, "R1 empty table");

    set_table_a();
    do_load(80);
    // back-to-back stream, first query in the cycle the strobe is low
    for (int k = 0; k <= NV; k++) begin
      if (k > 0) begin
        string tag;
        tag = (k == 1) ? "R8" : (!VEC[k-1][37]) ? "R7" : (!VEC[k-1][4]) ? "R6" : "R4 R5";
        chk(tag, {res_vld, res_hit, res_idx}, {VEC[k-1][37], VEC[k-1][4:0]});
      end
      if (k < NV) begin
        qry_vld = VEC[k][37];
        qry_addr = VEC[k][36:5];
        @(negedge clk);
      end else qry_vld = 1'b0;
    end
    q1({8'd10, 8'd1, 8'd0, 8'd0}, 1'b1, 4'd1, "R12 base low bits ignored");
    q1({8'd100, 8'd64, 8'd0, 8'd0}, 1'b1, 4'd15, "R2 last record");

    set_table_b();
    do_load(80);
    q1({8'd1, 8'd2, 8'd3, 8'd4}, 1'b1, 4'd0, "R3 clamp hit");
    q1({8'd1, 8'd2, 8'd3, 8'd5}, 1'b1, 4'd15, "R3 clamp and zero length");
    q1({8'd2, 8'd0, 8'd0, 8'd3}, 1'b1, 4'd3, "R13 lowest index wins");
    q1({8'd10, 8'd3, 8'd0, 8'd1}, 1'b1, 4'd15, "R11 table replaced");

    set_table_a();
    do_load(40);
    @(negedge clk);
    q1({8'd10, 8'd3, 8'd0, 8'd1}, 1'b1, 4'd15, "R9 partial load dropped");
    q1({8'd2, 8'd0, 8'd0, 8'd7}, 1'b1, 4'd7, "R9 old table kept");

    do_load(85);
    q1({8'd10, 8'd0, 8'd0, 8'd0}, 1'b1, 4'd0, "R10 extra bytes ignored");
    q1({8'd100, 8'd64, 8'd0, 8'd0}, 1'b1, 4'd15, "R10 last entry intact");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule